// File: doc/BRIEF.md
# Virtual Channel Input Arbiter

This block is the input-port stage of a mesh router. Flits arrive on a valid/ready stream, each tagged with the virtual channel (VC) index chosen by the upstream router's routing step. Each flit is written into a small per-VC FIFO. Every cycle the stage offers at most one flit to the output-port arbitration through a request/grant pair.

A VC may compete only when its FIFO holds a flit and the matching buffer in the next router has room, which a per-VC space bit reports. A matrix arbiter chooses among the VCs that may compete. When a head flit is accepted, the port locks onto that VC and offers nothing else until the tail flit of that packet has been accepted, so packets never interleave. A flit that is not granted stays at the head of its FIFO and is offered again. A flit leaves its FIFO only in a cycle in which it is both offered and granted.

Back-pressure rules: on the input side, `in_ready` shows whether the FIFO named by `in_vc` has a free slot, whatever the value of `in_valid`. A flit is taken on a clock edge where `in_valid` and `in_ready` are both high. On the output side, a flit is transferred on a clock edge where `req_valid` and `req_grant` are both high. `req_grant` has no effect while `req_valid` is low.

Top module: `vc_input_stage`

## Requirements
- R1: A flit presented with `in_valid` high and `in_ready` high is stored in the FIFO selected by `in_vc`. `in_ready` is low when that FIFO already holds DEPTH flits (4 by default). A flit offered while `in_ready` is low is dropped and is never delivered.
- R2: A VC is eligible only when its FIFO is non-empty and its `dn_space` bit is 1. `req_valid` is high only when the offered VC (`req_vc`) is eligible.
- R3: While the port is unlocked, the lowest-index eligible VC wins after reset. Each accepted win makes the winning VC lose to every other VC in later contests.
- R4: Flit types are encoded on 2 bits: 00 body, 01 head, 10 tail, 11 single. After a head flit from VC v is accepted, every offered flit comes from VC v until a tail flit from v has been accepted.
- R5: While the port is locked and the locked VC's FIFO is empty, `req_valid` stays low, even when other VCs are eligible.
- R6: A flit that is offered but not granted stays in its FIFO and is offered again with the same data, unless its VC loses downstream space.
- R7: A flit is removed only on an accepted transfer, and the flits of each VC leave in the order in which they were written.
- R8: An accepted single flit (type 11) does not lock the port, so another VC may be offered in the very next cycle.
- R9: The arbiter's priorities change only on an accepted transfer. A VC that is offered but not granted keeps its rank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming flit is valid |
| in_ready | output | 1 | FIFO selected by `in_vc` has room |
| in_vc | input | VC_W | VC that receives the incoming flit |
| in_type | input | 2 | Incoming flit type (00 body, 01 head, 10 tail, 11 single) |
| in_data | input | DATA_W | Incoming flit payload |
| dn_space | input | NUM_VC | Per-VC: 1 when the next router's buffer can accept a flit |
| req_valid | output | 1 | A flit is offered to output arbitration |
| req_vc | output | VC_W | VC of the offered flit |
| req_type | output | 2 | Type of the offered flit |
| req_data | output | DATA_W | Payload of the offered flit |
| req_grant | input | 1 | Output arbitration accepts the offered flit |

## Verification
Two pairs of functions can fall in the same cycle. First, a write into a VC FIFO can coincide with a pop from that same FIFO. Second, a grant can land in the same cycle as a change in `dn_space` or in the lock. A stress phase drives random writes to all four VCs, random space bits and random grants, so same-cycle write/pop and grant/space collisions happen often. A scoreboard holds one queue per VC and checks, on every transfer, that the payload and type match in order, and that no flit from another VC appears inside an open packet. Directed phases then provoke a single-flit transfer and a competing request in adjacent cycles, and a lock held over an empty FIFO while other VCs are ready.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    FLIT_BODY   = 2'b00,
    FLIT_HEAD   = 2'b01,
    FLIT_TAIL   = 2'b10,
    FLIT_SINGLE = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/vc_fifo.sv
module vc_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;

  assign empty   = (count == '0);
  assign full    = (count == CAP);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/vc_matrix_arb.sv
module vc_matrix_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  input  logic [N-1:0] accept
);
  // beats[i][j] == 1 : requester i wins over requester j
  logic [N-1:0] beats [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && req[j] && beats[j][i]) gnt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          beats[i][j] <= (i < j);
    end else if (|accept) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          if (i == j)         beats[i][j] <= 1'b0;
          else if (accept[i]) beats[i][j] <= 1'b0;
          else if (accept[j]) beats[i][j] <= 1'b1;
        end
    end
  end
endmodule

// File: rtl/vc_pkt_lock.sv
module vc_pkt_lock #(
  parameter int VC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [VC_W-1:0] fire_vc,
  input  logic [1:0]      fire_kind,
  output logic            locked,
  output logic [VC_W-1:0] lock_vc
);
  import vc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      lock_vc <= '0;
    end else if (fire) begin
      if (!locked && fire_kind == FLIT_HEAD) begin
        locked  <= 1'b1;
        lock_vc <= fire_vc;
      end else if (locked && (fire_kind == FLIT_TAIL || fire_kind == FLIT_SINGLE)) begin
        locked  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vc_input_stage.sv
module vc_input_stage #(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VC_W-1:0]   in_vc,
  input  logic [1:0]        in_type,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NUM_VC-1:0] dn_space,
  output logic              req_valid,
  output logic [VC_W-1:0]   req_vc,
  output logic [1:0]        req_type,
  output logic [DATA_W-1:0] req_data,
  input  logic              req_grant
);
  localparam int FW = DATA_W + 2;

  logic [NUM_VC-1:0] q_empty, q_full, q_wr, q_rd, elig;
  logic [FW-1:0]     q_head [NUM_VC];
  logic [NUM_VC-1:0] arb_req, arb_gnt, arb_acc;
  logic [VC_W-1:0]   win_vc, offer_vc, lock_vc;
  logic              locked, fire;

  genvar v;
  generate
    for (v = 0; v < NUM_VC; v++) begin : g_vc
      assign q_wr[v] = in_valid && (in_vc == VC_W'(v)) && !q_full[v];
      assign q_rd[v] = fire && (offer_vc == VC_W'(v));
      vc_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (q_wr[v]),
        .wr_data ({in_type, in_data}),
        .rd_en   (q_rd[v]),
        .rd_data (q_head[v]),
        .empty   (q_empty[v]),
        .full    (q_full[v])
      );
    end
  endgenerate

  assign in_ready = !q_full[in_vc];
  assign elig     = ~q_empty & dn_space;
  assign arb_req  = locked ? '0 : elig;

  vc_matrix_arb #(.N(NUM_VC)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (arb_req),
    .gnt    (arb_gnt),
    .accept (arb_acc)
  );

  always_comb begin
    win_vc = '0;
    for (int i = 0; i < NUM_VC; i++)
      if (arb_gnt[i]) win_vc = VC_W'(i);
  end

  assign offer_vc  = locked ? lock_vc : win_vc;
  assign req_valid = locked ? elig[lock_vc] : (|elig);
  assign req_vc    = offer_vc;
  assign req_type  = q_head[offer_vc][DATA_W +: 2];
  assign req_data  = q_head[offer_vc][DATA_W-1:0];
  assign fire      = req_valid && req_grant;
  assign arb_acc   = (fire && !locked) ? arb_gnt : '0;

  vc_pkt_lock #(.VC_W(VC_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fire_vc   (offer_vc),
    .fire_kind (req_type),
    .locked    (locked),
    .lock_vc   (lock_vc)
  );
endmodule

// File: rtl/vc_input_stage_chk.sv
module vc_input_stage_chk #(
  parameter int NUM_VC = 4,
  parameter int DATA_W = 16,
  parameter int VC_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_grant,
  input logic [VC_W-1:0]   req_vc,
  input logic [1:0]        req_type,
  input logic [DATA_W-1:0] req_data,
  input logic [NUM_VC-1:0] dn_space,
  input logic [NUM_VC-1:0] arb_gnt,
  input logic              locked,
  input logic [VC_W-1:0]   lock_vc
);
  p_offer_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> dn_space[req_vc]);

  p_single_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_gnt));

  p_head_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grant && !locked && req_type == 2'b01)
      |=> (locked && lock_vc == $past(req_vc)));

  p_locked_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && req_valid) |-> (req_vc == lock_vc));

  p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(req_valid && req_grant)) |=> (locked && lock_vc == $past(lock_vc)));

  p_retry_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && req_valid && !req_grant)
      |=> (!dn_space[$past(req_vc)] ||
           (req_valid && req_vc == $past(req_vc) && req_data == $past(req_data))));

  p_single_nolock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grant && !locked && req_type == 2'b11) |=> !locked);
endmodule

bind vc_input_stage vc_input_stage_chk #(
  .NUM_VC (NUM_VC),
  .DATA_W (DATA_W),
  .VC_W   (VC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_grant (req_grant),
  .req_vc    (req_vc),
  .req_type  (req_type),
  .req_data  (req_data),
  .dn_space  (dn_space),
  .arb_gnt   (arb_gnt),
  .locked    (locked),
  .lock_vc   (lock_vc)
);

// File: tb/vc_input_stage_tb.sv
module vc_input_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int DW = 16;
  localparam logic [1:0] K_BODY = 2'b00, K_HEAD = 2'b01, K_TAIL = 2'b10, K_SINGLE = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, req_grant = 1'b0;
  logic in_ready, req_valid;
  logic [1:0] in_vc = '0, in_type = '0, req_vc, req_type;
  logic [DW-1:0] in_data = '0, req_data;
  logic [NV-1:0] dn_space = '1;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [17:0] expq [NV][$];
  int open_vc = -1;
  int gen_left [NV];
  int prop_len [NV];
  int seq [NV];
  int hs_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_input_stage #(.NUM_VC(NV), .DEPTH(4), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vc(in_vc), .in_type(in_type), .in_data(in_data), .dn_space(dn_space),
    .req_valid(req_valid), .req_vc(req_vc), .req_type(req_type),
    .req_data(req_data), .req_grant(req_grant)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic put_flit(input int v, input logic [1:0] k, input logic [DW-1:0] d);
    cyc();
    in_valid = 1'b1; in_vc = 2'(v); in_type = k; in_data = d;
    cyc();
    in_valid = 1'b0;
  endtask

  task automatic grant_one();
    cyc();
    req_grant = 1'b1;
    cyc();
    req_grant = 1'b0;
  endtask

  // Scoreboard monitor: inputs and outputs are stable at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) begin
        expq[in_vc].push_back({in_type, in_data});
        if (gen_left[in_vc] == 0) gen_left[in_vc] = prop_len[in_vc] - 1;
        else gen_left[in_vc] = gen_left[in_vc] - 1;
        seq[in_vc] = seq[in_vc] + 1;
      end
      if (req_valid && req_grant) begin
        logic [17:0] got, want;
        hs_count++;
        got = {req_type, req_data};
        if (expq[req_vc].size() == 0) begin
          chk(1'b0, "R7", "transfer from empty expectation", int'(req_vc), -1);
        end else begin
          want = expq[req_vc].pop_front();
          chk(got == want, "R7", "flit order/content", int'(got), int'(want));
        end
        if (open_vc >= 0)
          chk(int'(req_vc) == open_vc, "R4", "interleaved packet vc", int'(req_vc), open_vc);
        if (req_type == K_HEAD) open_vc = int'(req_vc);
        else if (req_type == K_TAIL) open_vc = -1;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) begin gen_left[v] = 0; prop_len[v] = 1; seq[v] = 0; end
    repeat (3) cyc();
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R2", "reset req_valid", int'(req_valid), 0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);

    // Arbitration order and retry (R2, R3, R6, R9)
    put_flit(2, K_SINGLE, 16'h2001);
    put_flit(1, K_SINGLE, 16'h1001);
    @(negedge clk);
    chk(req_valid && req_vc == 2'd1, "R3", "reset priority lowest index", int'(req_vc), 1);
    cyc(); dn_space = 4'b1101;
    @(negedge clk);
    chk(req_valid && req_vc == 2'd2, "R2", "vc without space masked", int'(req_vc), 2);
    cyc(); dn_space = 4'b0000;
    @(negedge clk);
    chk(req_valid == 1'b0, "R2", "no space anywhere", int'(req_valid), 0);
    cyc(); dn_space = 4'b1111;
    cyc();
    @(negedge clk);
    chk(req_vc == 2'd1 && req_data == 16'h1001, "R9", "rank kept without accept", int'(req_vc), 1);
    chk(req_data == 16'h1001, "R6", "ungranted flit retried", int'(req_data), 16'h1001);
    grant_one();
    put_flit(1, K_SINGLE, 16'h1002);
    @(negedge clk);
    chk(req_valid && req_vc == 2'd2, "R3", "winner demoted after accept", int'(req_vc), 2);
    grant_one();
    @(negedge clk);
    chk(req_valid && req_vc == 2'd1, "R3", "second demotion", int'(req_vc), 1);
    grant_one();
    @(negedge clk);
    chk(req_valid == 1'b0, "R7", "all drained", int'(req_valid), 0);

    // FIFO full (R1)
    for (int i = 0; i < 4; i++) put_flit(0, K_SINGLE, 16'h0100 + 16'(i));
    cyc(); in_vc = 2'd0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1", "full vc not ready", int'(in_ready), 0);
    cyc(); in_vc = 2'd3;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "other vc ready", int'(in_ready), 1);
    put_flit(0, K_SINGLE, 16'h01FF);
    cyc(); req_grant = 1'b1;
    repeat (4) cyc();
    req_grant = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1", "overflow flit dropped", int'(req_valid), 0);

    // Lock across an empty VC (R4, R5)
    put_flit(0, K_HEAD, 16'hA000);
    grant_one();
    put_flit(1, K_SINGLE, 16'hB000);
    put_flit(2, K_SINGLE, 16'hB100);
    @(negedge clk);
    chk(req_valid == 1'b0, "R5", "stall on empty locked vc", int'(req_valid), 0);
    cyc(); req_grant = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R5", "grant ignored while stalled", int'(req_valid), 0);
    cyc(); req_grant = 1'b0;
    put_flit(0, K_BODY, 16'hA001);
    @(negedge clk);
    chk(req_valid && req_vc == 2'd0, "R4", "locked vc offered", int'(req_vc), 0);
    grant_one();
    put_flit(0, K_TAIL, 16'hA002);
    @(negedge clk);
    chk(req_valid && req_vc == 2'd0 && req_type == K_TAIL, "R4", "tail from locked vc", int'(req_vc), 0);
    grant_one();
    @(negedge clk);
    chk(req_valid && req_vc != 2'd0, "R4", "lock released after tail", int'(req_vc), 1);
    cyc(); req_grant = 1'b1;
    repeat (2) cyc();
    req_grant = 1'b0;

    // Single flits back to back (R8)
    put_flit(3, K_SINGLE, 16'hC300);
    put_flit(2, K_SINGLE, 16'hC200);
    cyc(); req_grant = 1'b1;
    @(negedge clk);
    chk(req_valid, "R8", "first single offered", int'(req_valid), 1);
    @(negedge clk);
    chk(req_valid, "R8", "next vc offered right after single", int'(req_valid), 1);
    cyc(); req_grant = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b0, "R8", "both singles delivered", int'(req_valid), 0);

    // Random stress with scoreboard (R1..R7)
    for (int c = 0; c < 4000; c++) begin
      int v;
      cyc();
      v = $urandom_range(0, NV-1);
      if (gen_left[v] == 0) prop_len[v] = $urandom_range(1, 4);
      in_vc = 2'(v);
      in_type = (gen_left[v] == 0) ? ((prop_len[v] == 1) ? K_SINGLE : K_HEAD)
                                   : ((gen_left[v] == 1) ? K_TAIL : K_BODY);
      in_data = {2'(v), 14'(seq[v])};
      in_valid = ($urandom_range(0, 3) != 0);
      dn_space = 4'($urandom);
      req_grant = ($urandom_range(0, 2) != 0);
    end
    // finish open packets, then drain
    dn_space = '1; req_grant = 1'b1;
    for (int c = 0; c < 2000; c++) begin
      int pick;
      cyc();
      pick = -1;
      for (int v = 0; v < NV; v++) if (gen_left[v] != 0 && pick < 0) pick = v;
      if (pick < 0) begin
        in_valid = 1'b0;
      end else begin
        in_vc = 2'(pick);
        in_type = (gen_left[pick] == 1) ? K_TAIL : K_BODY;
        in_data = {2'(pick), 14'(seq[pick])};
        in_valid = 1'b1;
      end
    end
    in_valid = 1'b0;
    repeat (20) cyc();
    @(negedge clk);
    for (int v = 0; v < NV; v++)
      chk(expq[v].size() == 0, "R7", "scoreboard queue empty", expq[v].size(), 0);
    chk(hs_count > 500, "R6", "stress transfers occurred", hs_count, 501);
    chk(open_vc == -1, "R4", "no packet left open", open_vc, -1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule